// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with Non-Maskable Input

This block decides which interrupt a small 8-bit core services next. It gathers one active-low non-maskable pin, a set of level-sensitive external lines and a set of sticky peripheral flags with their own enable bits. It presents a single request with a vector number to the core. The core answers with a one-cycle entry acknowledge and later with a one-cycle return pulse. The controller keeps a small service state machine so that it can enforce the nesting rules. A non-maskable routine may cut into a normal routine. Nothing may cut into a non-maskable routine, and no normal request may cut into any routine.

The non-maskable pin passes through a two-flop synchronizer. A falling edge then sets a pending latch, whatever the global enable is doing. The latch clears when the core acknowledges vector 0. Two wake outputs serve the low-power modes. The wait-wake output rises on any pending request. The stop-wake output rises only for sources that a per-source mask selects, and the external lines always count as selected.

Service states: `ST_IDLE` (nothing in service), `ST_NORM` (a vectored routine runs), `ST_NMI` (non-maskable routine entered from idle), `ST_NMI_NEST` (non-maskable routine on top of a vectored routine). Transitions: IDLE→NMI and IDLE→NORM on an acknowledge of vector 0 or of a vectored request. NORM→NMI_NEST on an acknowledge of vector 0. NMI→IDLE, NMI_NEST→NORM and NORM→IDLE on a return pulse. Reset forces any state to IDLE.

Top module: `intc_top`

## Requirements
- R1: Reset puts the controller in idle and clears the non-maskable latch; `irq_req`, `wake_wait` and `wake_stop` are low after reset with no inputs active, and a routine in service is abandoned.
- R2: A falling edge on `nmi_n` is seen through two synchronizer flops. `irq_req` rises with `irq_vec`=0 after the third rising clock edge following the pin fall, not after the second, and independently of `glob_en`.
- R3: An acknowledge (`ack` high while `irq_req` is high) of vector 0 clears the non-maskable latch, so `irq_req` and `wake_wait` fall when nothing else is pending.
- R4: A pending non-maskable request is offered (vector 0) while a vectored routine is in service, and is not offered while a non-maskable routine is in service.
- R5: While any routine is in service, no vectored request (vector 1 and above) is offered; it stays pending.
- R6: Vectored sources have fixed priority, the lowest vector number winning: `ext_line[i]` is vector i+1 and `per_flag[j]` is vector N_EXT+1+j. `irq_vec` is the binary vector number.
- R7: An external line requests only while `glob_en` is high. A peripheral requests only when its flag, its `per_en` bit and `glob_en` are all high.
- R8: A return pulse closes only the innermost level: NMI_NEST→NORM, NMI→IDLE, NORM→IDLE. A return pulse in idle has no effect.
- R9: `wake_wait` is high whenever the non-maskable latch is set or any vectored source requests, whatever the service state.
- R10: `wake_stop` is high only for pending sources whose `stop_mask` bit is set (bit 0 for the non-maskable source, bit v for vector v). The external-line bits are treated as always set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n | input | 1 | Asynchronous active-low non-maskable pin |
| glob_en | input | 1 | Global enable for vectored sources |
| ext_line | input | N_EXT | Level external requests, vectors 1..N_EXT |
| per_flag | input | N_PER | Sticky peripheral flags |
| per_en | input | N_PER | Peripheral local enables |
| stop_mask | input | N_EXT+N_PER+1 | Per-source stop-wake selection |
| ack | input | 1 | Core entry acknowledge pulse |
| reti | input | 1 | Core return-from-interrupt pulse |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | clog2(N_EXT+N_PER+1) | Vector number of the request |
| wake_wait | output | 1 | Wake from wait mode |
| wake_stop | output | 1 | Wake from stop mode |

## Verification
The assertions take for granted that `ack` comes only as a single-cycle pulse answering a visible request. They also assume that `reti` arrives only once per routine that was entered, and that it never arrives in the same cycle as an acknowledge. The stimulus drives both pulses for exactly one clock, well clear of the clock edge. It issues returns only after an entry, except for one deliberate return in idle. The non-maskable pin is held high across every reset release so that the synchronizer never sees a false edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_NORM,
        ST_NMI,
        ST_NMI_NEST
    } svc_state_t;
endpackage

// File: rtl/intc_nmi_edge.sv
module intc_nmi_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic clr,
    output logic pend
);
    // sh[0] is the first synchronizer flop, sh[SYNC_STAGES-1] the synced
    // level, sh[SYNC_STAGES] its previous value for the edge detector.
    logic [SYNC_STAGES:0] sh;
    logic                 fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[SYNC_STAGES-1:0], pin_n};
    end

    assign fall = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pend <= 1'b0;
        else if (fall) pend <= 1'b1;
        else if (clr)  pend <= 1'b0;
    end

    assert_nmi_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> pend);
    assert_nmi_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fall) |=> !pend);
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
    parameter int N  = 4,
    parameter int VW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [VW-1:0] vec
);
    // Bit i is vector i+1; scanning downward leaves the lowest vector.
    always_comb begin
        any = |req;
        vec = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) vec = VW'(i + 1);
        end
    end
endmodule

// File: rtl/intc_wake.sv
module intc_wake #(
    parameter int N_EXT = 2,
    parameter int N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_pend,
    input  logic [N_SRC-1:0] stop_mask,
    output logic             wake_wait,
    output logic             wake_stop
);
    logic [N_SRC-1:0] eff_mask;

    for (genvar g = 0; g < N_SRC; g++) begin : g_mask
        if (g >= 1 && g <= N_EXT) begin : g_ext
            assign eff_mask[g] = 1'b1;
        end else begin : g_sel
            assign eff_mask[g] = stop_mask[g];
        end
    end

    assign wake_wait = |src_pend;
    assign wake_stop = |(src_pend & eff_mask);

    assert_stop_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_stop |-> wake_wait);
endmodule

// File: rtl/intc_top.sv
module intc_top #(
    parameter int N_EXT       = 2,
    parameter int N_PER       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   nmi_n,
    input  logic                                   glob_en,
    input  logic [N_EXT-1:0]                       ext_line,
    input  logic [N_PER-1:0]                       per_flag,
    input  logic [N_PER-1:0]                       per_en,
    input  logic [N_EXT+N_PER:0]                   stop_mask,
    input  logic                                   ack,
    input  logic                                   reti,
    output logic                                   irq_req,
    output logic [$clog2(N_EXT+N_PER+1)-1:0]       irq_vec,
    output logic                                   wake_wait,
    output logic                                   wake_stop
);
    import intc_pkg::*;

    localparam int N_VEC = N_EXT + N_PER;
    localparam int N_SRC = N_VEC + 1;
    localparam int VEC_W = $clog2(N_SRC);

    svc_state_t       state, state_nx;
    logic             nmi_pend, nmi_clr, nmi_ok, take;
    logic [N_VEC-1:0] vec_pend;
    logic             vec_any;
    logic [VEC_W-1:0] enc_vec;

    // Source qualification: external lines first, then peripherals.
    for (genvar e = 0; e < N_EXT; e++) begin : g_ext
        assign vec_pend[e] = ext_line[e] & glob_en;
    end
    for (genvar p = 0; p < N_PER; p++) begin : g_per
        assign vec_pend[N_EXT+p] = per_flag[p] & per_en[p] & glob_en;
    end

    intc_nmi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
        .clk(clk), .rst_n(rst_n), .pin_n(nmi_n), .clr(nmi_clr), .pend(nmi_pend)
    );

    intc_prio_enc #(.N(N_VEC), .VW(VEC_W)) u_enc (
        .req(vec_pend), .any(vec_any), .vec(enc_vec)
    );

    intc_wake #(.N_EXT(N_EXT), .N_SRC(N_SRC)) u_wake (
        .clk(clk), .rst_n(rst_n), .src_pend({vec_pend, nmi_pend}),
        .stop_mask(stop_mask), .wake_wait(wake_wait), .wake_stop(wake_stop)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take) state_nx = (irq_vec == '0) ? ST_NMI : ST_NORM;
            end
            ST_NORM: begin
                if (take)      state_nx = ST_NMI_NEST;
                else if (reti) state_nx = ST_IDLE;
            end
            ST_NMI: begin
                if (reti) state_nx = ST_IDLE;
            end
            ST_NMI_NEST: begin
                if (reti) state_nx = ST_NORM;
            end
        endcase
    end

    // Outputs
    always_comb begin
        nmi_ok  = (state == ST_IDLE) || (state == ST_NORM);
        irq_req = (nmi_pend && nmi_ok) || ((state == ST_IDLE) && vec_any);
        irq_vec = (nmi_pend && nmi_ok) ? '0 : enc_vec;
        take    = ack && irq_req;
        nmi_clr = take && (irq_vec == '0);
    end

    assert_nmi_no_reenter_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_NMI) || (state == ST_NMI_NEST)) |-> !irq_req);
    assert_no_preempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_NORM) && irq_req) |-> (irq_vec == '0));
    assert_nmi_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && (state == ST_IDLE)) |-> (irq_req && (irq_vec == '0)));
    assert_vec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec <= VEC_W'(N_VEC)));
    assert_reti_inner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_NMI_NEST) && reti) |=> (state == ST_NORM));
    assert_wait_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> wake_wait);
endmodule

// File: tb/test_intc_top.sv
`timescale 1ns/1ps
module test_intc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_n = 1'b1;
    logic       glob_en = 1'b0;
    logic [1:0] ext_line = '0;
    logic [1:0] per_flag = '0;
    logic [1:0] per_en = '0;
    logic [4:0] stop_mask = '0;
    logic       ack = 1'b0;
    logic       reti = 1'b0;
    logic       irq_req, wake_wait, wake_stop;
    logic [2:0] irq_vec;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    intc_top i_intc_top (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .glob_en(glob_en),
        .ext_line(ext_line), .per_flag(per_flag), .per_en(per_en),
        .stop_mask(stop_mask), .ack(ack), .reti(reti), .irq_req(irq_req),
        .irq_vec(irq_vec), .wake_wait(wake_wait), .wake_stop(wake_stop)
    );

    // Row: {glob_en, ext_line[1:0], per_flag[1:0], per_en[1:0], req, vec[2:0]}
    localparam logic [10:0] TBL [9] = '{
        {1'b0, 2'b11, 2'b11, 2'b11, 1'b0, 3'd0},  // R7 global enable off
        {1'b1, 2'b00, 2'b00, 2'b11, 1'b0, 3'd0},  // R7 no flags
        {1'b1, 2'b01, 2'b11, 2'b11, 1'b1, 3'd1},  // R6 vector 1 wins
        {1'b1, 2'b10, 2'b11, 2'b11, 1'b1, 3'd2},  // R6 vector 2 over peripherals
        {1'b1, 2'b00, 2'b11, 2'b11, 1'b1, 3'd3},  // R6 vector 3 over 4
        {1'b1, 2'b00, 2'b10, 2'b11, 1'b1, 3'd4},  // R6 vector 4 alone
        {1'b1, 2'b00, 2'b11, 2'b01, 1'b1, 3'd3},  // R7 local enable masks 4
        {1'b1, 2'b00, 2'b11, 2'b10, 1'b1, 3'd4},  // R7 local enable masks 3
        {1'b1, 2'b00, 2'b01, 2'b10, 1'b0, 3'd0}   // R7 flag without enable
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        step(1);
        ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1;
        step(1);
        reti = 1'b0;
    endtask

    task automatic nmi_fire();
        nmi_n = 1'b1;
        step(3);
        nmi_n = 1'b0;
        step(3);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 irq_req", irq_req, 0);
        chk("R1 wake_wait", wake_wait, 0);
        chk("R1 wake_stop", wake_stop, 0);

        // Table walk in idle
        for (int r = 0; r < 9; r++) begin
            {glob_en, ext_line, per_flag, per_en} = TBL[r][10:4];
            step(1);
            chk("R6/R7 irq_req", irq_req, int'(TBL[r][3]));
            if (TBL[r][3]) chk("R6 irq_vec", irq_vec, int'(TBL[r][2:0]));
            chk("R9 wake_wait", wake_wait, int'(TBL[r][3]));
        end
        glob_en = 1'b0; ext_line = '0; per_flag = '0; per_en = '0;
        step(1);

        // R2 synchronizer latency with global enable off
        nmi_n = 1'b0;
        step(2);
        chk("R2 not yet", irq_req, 0);
        step(1);
        chk("R2 irq_req", irq_req, 1);
        chk("R2 irq_vec", irq_vec, 0);
        chk("R9 wake_wait nmi", wake_wait, 1);
        chk("R10 stop mask off", wake_stop, 0);
        stop_mask = 5'b00001;
        step(1);
        chk("R10 stop mask on", wake_stop, 1);
        stop_mask = '0;

        // R3 acknowledge clears latch
        pulse_ack();
        chk("R3 irq_req", irq_req, 0);
        chk("R3 wake_wait", wake_wait, 0);

        // R4 no NMI over NMI
        nmi_fire();
        chk("R4 nmi blocked", irq_req, 0);
        chk("R9 wake_wait in service", wake_wait, 1);
        pulse_reti();
        chk("R8 nmi return req", irq_req, 1);
        chk("R8 nmi return vec", irq_vec, 0);
        pulse_ack();
        pulse_reti();
        chk("R8 back to idle", irq_req, 0);

        // Vectored routine, then NMI nesting
        glob_en = 1'b1; per_flag = 2'b01; per_en = 2'b11;
        step(1);
        chk("R7 periph vec", irq_vec, 3);
        pulse_ack();
        chk("R5 no reoffer", irq_req, 0);
        ext_line = 2'b01;
        step(1);
        chk("R5 ext held", irq_req, 0);
        chk("R9 wake held", wake_wait, 1);
        nmi_fire();
        chk("R4 nmi preempts req", irq_req, 1);
        chk("R4 nmi preempts vec", irq_vec, 0);
        pulse_ack();
        chk("R4 nested no req", irq_req, 0);
        pulse_reti();
        chk("R8 inner only", irq_req, 0);
        pulse_reti();
        chk("R8 idle req", irq_req, 1);
        chk("R6 ext wins", irq_vec, 1);
        pulse_reti();
        chk("R8 idle reti ignored req", irq_req, 1);
        chk("R8 idle reti ignored vec", irq_vec, 1);

        // R10 stop wake per source
        nmi_n = 1'b1;
        stop_mask = '0;
        ext_line = 2'b10;
        step(1);
        chk("R10 ext forced", wake_stop, 1);
        ext_line = '0; per_flag = 2'b10;
        step(1);
        chk("R10 periph unmasked", wake_stop, 0);
        stop_mask = 5'b10000;
        step(1);
        chk("R10 periph masked in", wake_stop, 1);

        // R1 reset aborts a routine
        pulse_ack();
        chk("R1 in service", irq_req, 0);
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        step(1);
        chk("R1 abort req", irq_req, 1);
        chk("R1 abort vec", irq_vec, 4);

        // R1 reset clears latch
        glob_en = 1'b0; per_flag = '0; stop_mask = '0;
        nmi_fire();
        chk("R2 latch set", irq_req, 1);
        nmi_n = 1'b1;
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        step(1);
        chk("R1 latch cleared", irq_req, 0);
        chk("R1 wake cleared", wake_wait, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule